// File: doc/BRIEF.md
# Microsecond Tick Timer

The block is a free-running timer that advances once per microsecond. A programmable prescaler divides the bus clock down to a one-cycle tick strobe, and a counter steps by one on each strobe. The counter is compared with a compare register on every tick. A match raises a sticky interrupt request. This request can feed a separate interrupt controller. When clear-on-compare is enabled, a match also restarts the counter from zero and bumps a 4-bit overflow tally.

Software reaches everything through a byte-wide register bus. Writes take effect on the next clock edge. Reads are combinational from the current address. To get exact 1 µs ticks, load the prescaler adjust byte with 256 minus the bus clock frequency in MHz; at 50 MHz that value is 206. The bus carries no data stream, so it has no valid/ready pair and no back-pressure: every write is accepted in the cycle it is presented, and every read is answered in the same cycle.

Top module: `usec_tick_timer`

## Requirements
- R1: After reset, the counter, the compare register, the control byte, the adjust byte, the overflow tally, `irq` and `usec_strobe` are all zero.
- R2: While enabled, an 8-bit prescaler steps once per clock. When it is at 255, `usec_strobe` is high for that cycle and the prescaler reloads from the adjust byte, so strobes come every 256 − adjust clocks. The counter is one higher in the cycle after each strobe.
- R3: While control bit 0 (enable) is 0, `usec_strobe` stays low, and the prescaler and counter hold their values.
- R4: A strobe in a cycle where counter equals compare sets `irq` from the next cycle, whether or not clear-on-compare is on. `irq` stays set until `irq_ack` is high at a clock edge. If a match and `irq_ack` arrive in the same cycle, the match wins.
- R5: With control bit 1 (clear-on-compare) set, a strobe on a match loads the counter with 0 and increments the overflow tally modulo 16.
- R6: With clear-on-compare off, the counter runs past the compare value and wraps from all-ones to 0 with the overflow tally unchanged.
- R7: The control byte at address 8 reads {tally[3:0], 0, 0, clear-on-compare, enable}. Writing it loads bits 1:0. Writing 1 to bit 2 zeroes the tally, and this clear wins over a same-cycle increment.
- R8: Counter byte k sits at address 4+k and holds bits 8k+7:8k. A write to any counter byte lands on the next edge and overrides that cycle's increment or clear; the other bytes keep their old value.
- R9: Compare byte k sits at address k and reads back what was written. Addresses 10 to 15 read 0, and writes to them change nothing.
- R10: The prescaler adjust byte sits at address 9 and reads back what was written. A write does not disturb the prescaler's current position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe for the register bus |
| bus_addr | input | 4 | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| irq_ack | input | 1 | Clears the interrupt request at the next edge |
| irq | output | 1 | Sticky compare-match interrupt request |
| usec_strobe | output | 1 | One-cycle tick pulse |

## Verification
The bench uses the default parameters: a 32-bit counter, an 8-bit prescaler and a 4-bit tally. Adjust values between 250 and 255 give strobes every one to six clocks, so many compare matches, acknowledge collisions and sixteen-match tally wraps fit in a short run. The 32-bit wrap boundary is reached by writing the counter to just below all-ones through its byte registers. The only long wait is the first 256-cycle prescaler pass after reset.

// File: rtl/tt_pkg.sv
package tt_pkg;
  localparam int unsigned BYTE_W        = 8;
  localparam int unsigned CTRL_RUN_BIT  = 0;
  localparam int unsigned CTRL_COC_BIT  = 1;
  localparam int unsigned CTRL_CLR_BIT  = 2;
  localparam int unsigned CTRL_OVF_LSB  = 4;

  typedef struct packed {
    logic coc;
    logic run;
  } tt_ctrl_t;
endpackage

// File: rtl/tt_prescaler.sv
module tt_prescaler #(
  parameter int unsigned PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [PRE_W-1:0] adj,
  output logic             strobe
);
  localparam logic [PRE_W-1:0] PRE_TOP = '1;

  logic [PRE_W-1:0] pre_q;

  assign strobe = run && (pre_q == PRE_TOP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_q <= '0;
    end else if (run) begin
      if (pre_q == PRE_TOP) pre_q <= adj;
      else                  pre_q <= pre_q + 1'b1;
    end
  end
endmodule

// File: rtl/tt_counter.sv
module tt_counter #(
  parameter int unsigned CNT_W = 32,
  parameter int unsigned OVF_W = 4,
  localparam int unsigned NB   = CNT_W / 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strobe,
  input  logic             coc,
  input  logic [CNT_W-1:0] cmp,
  input  logic [NB-1:0]    wr_be,
  input  logic [7:0]       wr_byte,
  input  logic             ovf_clr,
  output logic [CNT_W-1:0] cnt,
  output logic [OVF_W-1:0] ovf,
  output logic             match_ev
);
  logic [CNT_W-1:0] cnt_q, cnt_base, cnt_d;
  logic [OVF_W-1:0] ovf_q;
  logic             hit, wrap, any_wr;

  assign hit      = (cnt_q == cmp);
  assign match_ev = strobe && hit;
  assign wrap     = match_ev && coc;
  assign any_wr   = |wr_be;

  always_comb begin
    if (any_wr)      cnt_base = cnt_q;
    else if (wrap)   cnt_base = '0;
    else if (strobe) cnt_base = cnt_q + 1'b1;
    else             cnt_base = cnt_q;
  end

  for (genvar b = 0; b < NB; b++) begin : g_byte
    assign cnt_d[b*8 +: 8] = wr_be[b] ? wr_byte : cnt_base[b*8 +: 8];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ovf_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      if (ovf_clr)   ovf_q <= '0;
      else if (wrap) ovf_q <= ovf_q + 1'b1;
    end
  end

  assign cnt = cnt_q;
  assign ovf = ovf_q;
endmodule

// File: rtl/tt_irq_flag.sv
module tt_irq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic ack,
  output logic flag
);
  logic flag_q;

  always_ff @(posedge clk) begin
    if (!rst_n)   flag_q <= 1'b0;
    else if (set) flag_q <= 1'b1;
    else if (ack) flag_q <= 1'b0;
  end

  assign flag = flag_q;
endmodule

// File: rtl/tt_regs.sv
module tt_regs
  import tt_pkg::*;
#(
  parameter int unsigned ADDR_W    = 4,
  parameter int unsigned NB        = 4,
  parameter int unsigned PRE_W     = 8,
  parameter int unsigned OVF_W     = 4,
  parameter int unsigned CMP_BASE  = 0,
  parameter int unsigned CNT_BASE  = 4,
  parameter int unsigned CTRL_ADDR = 8,
  parameter int unsigned ADJ_ADDR  = 9,
  localparam int unsigned CNT_W    = NB * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic [CNT_W-1:0]  cnt_val,
  input  logic [OVF_W-1:0]  ovf_val,
  output logic [CNT_W-1:0]  cmp_val,
  output tt_ctrl_t          ctrl,
  output logic [PRE_W-1:0]  adj,
  output logic [NB-1:0]     cnt_be,
  output logic              ovf_clr
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_ADDR);
  localparam logic [ADDR_W-1:0] A_ADJ  = ADDR_W'(ADJ_ADDR);

  logic [CNT_W-1:0] cmp_q;
  tt_ctrl_t         ctrl_q;
  logic [PRE_W-1:0] adj_q;
  logic             wr_ctrl, wr_adj;

  assign wr_ctrl = bus_wr && (bus_addr == A_CTRL);
  assign wr_adj  = bus_wr && (bus_addr == A_ADJ);
  assign ovf_clr = wr_ctrl && bus_wdata[CTRL_CLR_BIT];

  for (genvar b = 0; b < NB; b++) begin : g_lane
    localparam logic [ADDR_W-1:0] A_CMP = ADDR_W'(CMP_BASE + b);
    localparam logic [ADDR_W-1:0] A_CNT = ADDR_W'(CNT_BASE + b);

    assign cnt_be[b] = bus_wr && (bus_addr == A_CNT);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cmp_q[b*8 +: 8] <= '0;
      end else if (bus_wr && (bus_addr == A_CMP)) begin
        cmp_q[b*8 +: 8] <= bus_wdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      adj_q  <= '0;
    end else begin
      if (wr_ctrl) begin
        ctrl_q.run <= bus_wdata[CTRL_RUN_BIT];
        ctrl_q.coc <= bus_wdata[CTRL_COC_BIT];
      end
      if (wr_adj) adj_q <= bus_wdata[PRE_W-1:0];
    end
  end

  always_comb begin
    bus_rdata = '0;
    for (int b = 0; b < int'(NB); b++) begin
      if (bus_addr == ADDR_W'(CMP_BASE + b)) bus_rdata = cmp_q[b*8 +: 8];
      if (bus_addr == ADDR_W'(CNT_BASE + b)) bus_rdata = cnt_val[b*8 +: 8];
    end
    if (bus_addr == A_CTRL) begin
      bus_rdata[CTRL_OVF_LSB +: OVF_W] = ovf_val;
      bus_rdata[CTRL_COC_BIT]          = ctrl_q.coc;
      bus_rdata[CTRL_RUN_BIT]          = ctrl_q.run;
    end
    if (bus_addr == A_ADJ) bus_rdata = BYTE_W'(adj_q);
  end

  assign cmp_val = cmp_q;
  assign ctrl    = ctrl_q;
  assign adj     = adj_q;
endmodule

// File: rtl/usec_tick_timer.sv
module usec_tick_timer
  import tt_pkg::*;
#(
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned PRE_W  = 8,
  parameter int unsigned OVF_W  = 4,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              irq_ack,
  output logic              irq,
  output logic              usec_strobe
);
  localparam int unsigned NB        = CNT_W / BYTE_W;
  localparam int unsigned CMP_BASE  = 0;
  localparam int unsigned CNT_BASE  = NB;
  localparam int unsigned CTRL_ADDR = 2 * NB;
  localparam int unsigned ADJ_ADDR  = 2 * NB + 1;

  logic [CNT_W-1:0] cnt, cmp;
  logic [OVF_W-1:0] ovf;
  logic [PRE_W-1:0] adj;
  logic [NB-1:0]    cnt_be;
  tt_ctrl_t         ctrl;
  logic             strobe, ovf_clr, match_ev;

  tt_regs #(
    .ADDR_W(ADDR_W), .NB(NB), .PRE_W(PRE_W), .OVF_W(OVF_W),
    .CMP_BASE(CMP_BASE), .CNT_BASE(CNT_BASE),
    .CTRL_ADDR(CTRL_ADDR), .ADJ_ADDR(ADJ_ADDR)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .cnt_val(cnt), .ovf_val(ovf),
    .cmp_val(cmp), .ctrl(ctrl), .adj(adj),
    .cnt_be(cnt_be), .ovf_clr(ovf_clr)
  );

  tt_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(ctrl.run), .adj(adj), .strobe(strobe)
  );

  tt_counter #(.CNT_W(CNT_W), .OVF_W(OVF_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .coc(ctrl.coc), .cmp(cmp),
    .wr_be(cnt_be), .wr_byte(bus_wdata), .ovf_clr(ovf_clr),
    .cnt(cnt), .ovf(ovf), .match_ev(match_ev)
  );

  tt_irq_flag u_irq (
    .clk(clk), .rst_n(rst_n), .set(match_ev), .ack(irq_ack), .flag(irq)
  );

  assign usec_strobe = strobe;
endmodule

// File: rtl/tt_checker.sv
module tt_checker #(
  parameter int unsigned CNT_W = 32,
  parameter int unsigned OVF_W = 4,
  parameter int unsigned NB    = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             strobe,
  input logic             run,
  input logic             coc,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] cmp,
  input logic [OVF_W-1:0] ovf,
  input logic [NB-1:0]    cnt_be,
  input logic             ovf_clr,
  input logic             irq,
  input logic             irq_ack
);
  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    strobe && (cnt_be == '0) && !(coc && cnt == cmp) |=> cnt == $past(cnt) + 1'b1);

  p_quiet_when_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !strobe);

  p_hold_when_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !run && (cnt_be == '0) |=> $stable(cnt));

  p_match_sets_irq_r4: assert property (@(posedge clk) disable iff (!rst_n)
    strobe && (cnt == cmp) |=> irq);

  p_irq_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !irq_ack |=> irq);

  p_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
    strobe && coc && (cnt == cmp) && (cnt_be == '0) |=> cnt == '0);

  p_tally_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    strobe && coc && (cnt == cmp) && !ovf_clr |=> ovf == $past(ovf) + 1'b1);

  p_tally_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_clr |=> ovf == '0);

  p_tally_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(strobe && coc && (cnt == cmp)) && !ovf_clr |=> $stable(ovf));
endmodule

bind usec_tick_timer tt_checker #(.CNT_W(CNT_W), .OVF_W(OVF_W), .NB(NB)) u_chk (
  .clk(clk), .rst_n(rst_n), .strobe(strobe), .run(ctrl.run), .coc(ctrl.coc),
  .cnt(cnt), .cmp(cmp), .ovf(ovf), .cnt_be(cnt_be), .ovf_clr(ovf_clr),
  .irq(irq), .irq_ack(irq_ack)
);

// File: tb/usec_tick_timer_tb.sv
`timescale 1ns/1ps
module usec_tick_timer_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       irq_ack = 1'b0;
  logic       irq, usec_strobe;

  always #5 clk = ~clk;

  usec_tick_timer u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_ack(irq_ack),
    .irq(irq), .usec_strobe(usec_strobe)
  );

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  // bench-side expectation, built from the requirements
  logic [7:0]  m_pre = '0, m_adj = '0;
  logic [31:0] m_cnt = '0, m_cmp = '0;
  logic [3:0]  m_ovf = '0;
  logic        m_run = 1'b0, m_coc = 1'b0, m_irq = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_rd(input logic [3:0] a);
    case (a)
      4'd0, 4'd1, 4'd2, 4'd3: return m_cmp[a[1:0]*8 +: 8];
      4'd4, 4'd5, 4'd6, 4'd7: return m_cnt[a[1:0]*8 +: 8];
      4'd8: return {m_ovf, 2'b00, m_coc, m_run};
      4'd9: return m_adj;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic exp_strobe();
    return m_run && (m_pre == 8'hFF);
  endfunction

  task automatic step(input logic we, input logic [3:0] a, input logic [7:0] d, input logic ack);
    logic tk, mev, wrap, cwr, clr;
    logic [7:0]  n_pre;
    logic [31:0] n_cnt;
    logic [3:0]  n_ovf;
    bus_wr = we; bus_addr = a; bus_wdata = d; irq_ack = ack;
    tk   = exp_strobe();
    mev  = tk && (m_cnt == m_cmp);
    wrap = mev && m_coc;
    cwr  = we && (a >= 4'd4) && (a <= 4'd7);
    clr  = we && (a == 4'd8) && d[2];
    n_pre = m_run ? ((m_pre == 8'hFF) ? m_adj : m_pre + 8'd1) : m_pre;
    n_cnt = wrap ? 32'd0 : (tk ? m_cnt + 32'd1 : m_cnt);
    if (cwr) begin
      n_cnt = m_cnt;
      n_cnt[a[1:0]*8 +: 8] = d;
    end
    n_ovf = clr ? 4'd0 : (wrap ? m_ovf + 4'd1 : m_ovf);
    @(posedge clk);
    #1;
    m_pre = n_pre; m_cnt = n_cnt; m_ovf = n_ovf;
    if (mev) m_irq = 1'b1;
    else if (ack) m_irq = 1'b0;
    if (we && a <= 4'd3) m_cmp[a[1:0]*8 +: 8] = d;
    if (we && a == 4'd8) begin m_run = d[0]; m_coc = d[1]; end
    if (we && a == 4'd9) m_adj = d;
    bus_wr = 1'b0; irq_ack = 1'b0;
    chk(irq == m_irq, "R4 irq", 32'(irq), 32'(m_irq));
    chk(usec_strobe == exp_strobe(), "R2 strobe", 32'(usec_strobe), 32'(exp_strobe()));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 4'd15, 8'h00, 1'b0);
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    step(1'b1, a, d, 1'b0);
  endtask

  task automatic wr32(input logic [3:0] base, input logic [31:0] v);
    for (int b = 0; b < 4; b++) wr(base + 4'(b), v[b*8 +: 8]);
  endtask

  task automatic rd_chk(input logic [3:0] a, input string tag);
    bus_addr = a;
    #1;
    chk(bus_rdata == exp_rd(a), tag, 32'(bus_rdata), 32'(exp_rd(a)));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    bad++; total++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finish_run();
  end

  initial begin
    logic [31:0] saved;
    int pulses;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1;
    for (int a = 0; a < 16; a++) rd_chk(4'(a), "R1 reset read");
    chk(irq == 1'b0, "R1 irq", 32'(irq), 0);
    chk(usec_strobe == 1'b0, "R1 strobe", 32'(usec_strobe), 0);
    rst_n = 1'b1;

    // R9 / R10: register readback
    wr(4'd9, 8'd252);
    rd_chk(4'd9, "R10 adjust readback");
    wr32(4'd0, 32'h0000_0005);
    for (int a = 0; a < 4; a++) rd_chk(4'(a), "R9 compare readback");

    // R2: first pass takes 256 clocks, then every 4
    wr(4'd8, 8'h01);
    idle(300);
    pulses = 0;
    for (int i = 0; i < 40; i++) begin
      idle(1);
      if (usec_strobe) pulses++;
    end
    chk(pulses == 10, "R2 strobe period", 32'(pulses), 32'd10);
    rd_chk(4'd4, "R2 count low byte");

    // R3: hold while disabled
    wr(4'd8, 8'h00);
    bus_addr = 4'd4; #1; saved = {24'd0, bus_rdata};
    idle(30);
    bus_addr = 4'd4; #1;
    chk({24'd0, bus_rdata} == saved, "R3 counter held", 32'(bus_rdata), saved);

    // R5 / R7: restart on match and tally wrap, fast strobe
    wr(4'd9, 8'd255);
    wr32(4'd4, 32'd0);
    wr(4'd8, 8'h03);
    for (int k = 0; k < 3; k++) begin
      idle(20);
      rd_chk(4'd8, "R5 tally in control byte");
      rd_chk(4'd4, "R5 restarted count");
    end
    idle(60);
    rd_chk(4'd8, "R5 tally modulo 16");
    wr(4'd8, 8'h07);
    rd_chk(4'd8, "R7 tally clear");

    // R6: wrap of all-ones without restart
    wr(4'd8, 8'h00);
    wr32(4'd4, 32'hFFFF_FFFD);
    wr32(4'd0, 32'h0000_0003);
    wr(4'd8, 8'h01);
    idle(8);
    for (int a = 4; a < 9; a++) rd_chk(4'(a), "R6 wrap past all-ones");

    // R8: byte write overrides the increment
    wr(4'd5, 8'hAB);
    for (int a = 4; a < 8; a++) rd_chk(4'(a), "R8 byte write");

    // R4: match and acknowledge in the same cycle
    wr(4'd8, 8'h00);
    wr32(4'd4, 32'h0000_0010);
    wr32(4'd0, 32'h0000_0010);
    step(1'b0, 4'd15, 8'h00, 1'b1);
    wr(4'd8, 8'h01);
    step(1'b0, 4'd15, 8'h00, 1'b1);
    chk(irq == 1'b1, "R4 match beats ack", 32'(irq), 1);
    step(1'b0, 4'd15, 8'h00, 1'b1);
    idle(2);

    // random mix
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = int'($urandom % 16);
      case (r)
        0, 1: wr(4'(4 + $urandom % 4), ($urandom % 2 == 0) ? 8'($urandom % 8) : 8'h00);
        2, 3: wr(4'($urandom % 4), ($urandom % 4 == 0) ? 8'($urandom % 8) : 8'h00);
        4:    wr(4'd8, {5'd0, 1'($urandom % 2), 1'($urandom % 2), 1'($urandom % 4 != 0)});
        5:    wr(4'd9, 8'(250 + $urandom % 6));
        6:    wr(4'(10 + $urandom % 6), 8'($urandom));
        7, 8: step(1'b0, 4'd15, 8'h00, 1'b1);
        default: idle(1);
      endcase
      if (i % 8 == 0) rd_chk(4'($urandom % 16), "R9 random readback");
    end
    finish_run();
  end
endmodule